// File: doc/BRIEF.md
# Carrier-Locked Conversion Trigger Timer

This block pairs one carrier timer with a parameterised number of trigger channels. It places analog-to-digital conversion requests at fixed, mirrored positions inside a triangular PWM carrier. The carrier timer repeatedly counts a programmable period downward. It drives a status level that tells whether the carrier is in its falling half or its rising half, and it issues a one-cycle strobe at the end of each period. Two periods make one carrier.

Each trigger channel holds its own compare value. Its counter steps downward while the carrier falls and upward while it rises, so a single compare value yields two trigger strobes per carrier, placed symmetrically around the carrier's midpoint. A single-cycle count enable stands in for the count clock. All channels advance only on cycles where it is high. Each channel has its own start and stop strobes.

Tick index i counts count-enable cycles from the alignment tick (i = 0), which is the first tick after a common start. P is the period value and S is a channel's compare value.

Top module: `adc_trig_pair`

## Requirements
- R1: A carrier start strobe loads the period value P into the carrier counter and drives the status output high. The first tick after the start is an alignment tick that keeps the value. Each later tick decrements the counter.
- R2: The carrier period strobe is high for exactly one clock, in the cycle after a tick that leaves the counter at zero. When started together with the channels, this happens at every tick i with i mod (P+1) = P.
- R3: A tick that finds the carrier counter at zero reloads P and inverts the status output.
- R4: After tick i, the status output is high (falling half) when floor(i/(P+1)) is even and low (rising half) when it is odd. It changes only on a tick or a start.
- R5: A trigger channel loads its compare value S on the first tick after its start strobe. On later ticks it steps down when the carrier's status after that tick is falling, and up when that status is rising.
- R6: A trigger channel drives a one-clock strobe in the cycle after any tick that leaves its counter at 0001h.
- R7: A carrier strobe seen while the status output is low makes the channel reload S on the next tick. With c = i mod (2P+2), this puts triggers at c = S-1 and c = 2P+1-S, which are 2(P+1-S) ticks apart.
- R8: A stop strobe freezes a channel's counter and status. It forces its strobes low until the next start strobe. A stop wins over a start in the same cycle.
- R9: The parameter NUM_SLV sets the number of trigger channels. Each has its own compare value, start, stop and trigger output, and stopping one leaves the others and the carrier unaffected.
- R10: A compare value is valid when 1 <= S <= P. Counters are 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Single-cycle count tick |
| mst_start | input | 1 | Carrier timer start strobe |
| mst_stop | input | 1 | Carrier timer stop strobe |
| mst_period | input | 16 | Carrier half-period value P |
| slv_start | input | NUM_SLV | Per-channel start strobes |
| slv_stop | input | NUM_SLV | Per-channel stop strobes |
| slv_cmp | input | 16*NUM_SLV | Per-channel compare values, channel k in bits [16k+15:16k] |
| mst_pulse | output | 1 | Carrier period-end strobe |
| mst_down | output | 1 | Carrier status, high while falling |
| slv_trig | output | NUM_SLV | Per-channel conversion trigger strobes |

## Verification
The embedded properties take for granted that the period and compare values stay steady while a channel runs, and that every compare value lies in the valid range of R10. The trigger positions of R7 hold only under those conditions. The stimulus draws P from 1 to 20 and each S from 1 to P. It changes these values only while all channels are stopped, and it starts the carrier and the channels in the same cycle, so the closed-form positions in R2, R4 and R7 apply directly. Count ticks arrive back to back or with short random gaps, so strobes that meet a following tick are covered.

// File: rtl/atp_pkg.sv
package atp_pkg;
    localparam int CNT_W = 16;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic run;
        logic loaded;
        logic down;
        cnt_t cnt;
    } car_st_t;

    typedef struct packed {
        logic run;
        logic loaded;
        logic pend;
        cnt_t cnt;
    } trg_st_t;

    function automatic cnt_t step_cnt(cnt_t v, logic dn);
        return dn ? cnt_t'(v - 1'b1) : cnt_t'(v + 1'b1);
    endfunction
endpackage

// File: rtl/atp_carrier.sv
module atp_carrier
    import atp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic stop,
    input  cnt_t period,
    output logic pulse,
    output logic down,
    output logic dir_dn
);
    car_st_t st;
    cnt_t    nxt;
    logic    at_zero;

    assign at_zero = (st.cnt == '0);
    assign nxt     = !st.loaded ? st.cnt : (at_zero ? period : cnt_t'(st.cnt - 1'b1));
    assign dir_dn  = !st.loaded ? 1'b1 : (at_zero ? ~st.down : st.down);
    assign down    = st.down;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '{run: 1'b0, loaded: 1'b0, down: 1'b1, cnt: '0};
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (stop) begin
                st.run <= 1'b0;
            end else if (start) begin
                st    <= '{run: 1'b1, loaded: 1'b0, down: 1'b1, cnt: period};
            end else if (st.run && tick) begin
                st.loaded <= 1'b1;
                st.cnt    <= nxt;
                if (st.loaded && at_zero) st.down <= ~st.down;
                pulse     <= (nxt == '0);
            end
        end
    end

    p_pulse_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));
    p_toggle_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (st.run && st.loaded && tick && at_zero && !start && !stop) |=> (down != $past(down)));
    p_status_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> $stable(down));
    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !st.run |-> !pulse);
endmodule

// File: rtl/atp_trigger.sv
module atp_trigger
    import atp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic stop,
    input  cnt_t cmp,
    input  logic car_pulse,
    input  logic car_down,
    input  logic car_dir_dn,
    output logic trig
);
    trg_st_t st;
    logic    reload;
    cnt_t    nxt;

    assign reload = st.pend || (car_pulse && !car_down);
    assign nxt    = (!st.loaded || reload) ? cmp : step_cnt(st.cnt, car_dir_dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '{run: 1'b0, loaded: 1'b0, pend: 1'b0, cnt: '0};
            trig <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (stop) begin
                st.run  <= 1'b0;
                st.pend <= 1'b0;
            end else if (start) begin
                st.run    <= 1'b1;
                st.loaded <= 1'b0;
                st.pend   <= 1'b0;
            end else if (st.run && tick) begin
                st.loaded <= 1'b1;
                st.pend   <= 1'b0;
                st.cnt    <= nxt;
                trig      <= (nxt == cnt_t'(1));
            end else if (st.run && car_pulse && !car_down) begin
                st.pend <= 1'b1;
            end
        end
    end

    p_trig_at_one_r6: assert property (@(posedge clk) disable iff (rst)
        trig |-> (st.cnt == cnt_t'(1)));
    p_first_load_r5: assert property (@(posedge clk) disable iff (rst)
        (st.run && !st.loaded && tick && !start && !stop) |=> (st.cnt == $past(cmp)));
    p_reload_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (st.run && st.loaded && tick && st.pend && !start && !stop) |=> (st.cnt == $past(cmp)));
    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !st.run |-> !trig);
endmodule

// File: rtl/adc_trig_pair.sv
module adc_trig_pair
    import atp_pkg::*;
#(
    parameter int NUM_SLV = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cnt_en,
    input  logic                       mst_start,
    input  logic                       mst_stop,
    input  logic [CNT_W-1:0]           mst_period,
    input  logic [NUM_SLV-1:0]         slv_start,
    input  logic [NUM_SLV-1:0]         slv_stop,
    input  logic [NUM_SLV*CNT_W-1:0]   slv_cmp,
    output logic                       mst_pulse,
    output logic                       mst_down,
    output logic [NUM_SLV-1:0]         slv_trig
);
    logic dir_dn;

    atp_carrier u_car (
        .clk    (clk),
        .rst    (rst),
        .tick   (cnt_en),
        .start  (mst_start),
        .stop   (mst_stop),
        .period (mst_period),
        .pulse  (mst_pulse),
        .down   (mst_down),
        .dir_dn (dir_dn)
    );

    // R9: one independent trigger channel per parameterised slot
    for (genvar k = 0; k < NUM_SLV; k++) begin : g_trg
        atp_trigger u_trg (
            .clk        (clk),
            .rst        (rst),
            .tick       (cnt_en),
            .start      (slv_start[k]),
            .stop       (slv_stop[k]),
            .cmp        (slv_cmp[k*CNT_W +: CNT_W]),
            .car_pulse  (mst_pulse),
            .car_down   (mst_down),
            .car_dir_dn (dir_dn),
            .trig       (slv_trig[k])
        );
    end
endmodule

// File: tb/sim_adc_trig_pair.sv
module sim_adc_trig_pair;
    localparam int NS = 2;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_en = 1'b0, mst_start = 1'b0, mst_stop = 1'b0;
    logic [15:0] mst_period = 16'd1;
    logic [NS-1:0] slv_start = '0, slv_stop = '0;
    logic [NS*16-1:0] slv_cmp = '0;
    logic mst_pulse, mst_down;
    logic [NS-1:0] slv_trig;

    int errs = 0, checks = 0;
    int tk = -1, P = 1;
    int S [NS];
    bit m_run = 0;
    bit s_run [NS];
    bit dn_exp = 1;

    always #5ns clk = ~clk;

    adc_trig_pair #(.NUM_SLV(NS)) u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .mst_start(mst_start), .mst_stop(mst_stop),
        .mst_period(mst_period), .slv_start(slv_start), .slv_stop(slv_stop), .slv_cmp(slv_cmp),
        .mst_pulse(mst_pulse), .mst_down(mst_down), .slv_trig(slv_trig)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s tick=%0d P=%0d actual=%0d expected=%0d", req, tk, P, act, exp);
        end
    endtask

    function automatic bit exp_pulse(int i, int p);
        return (i % (p + 1)) == p;
    endfunction
    function automatic bit exp_dn(int i, int p);
        return ((i / (p + 1)) % 2) == 0;
    endfunction
    function automatic bit exp_trig(int i, int p, int s);
        int c = i % (2 * p + 2);
        return (c == s - 1) || (c == 2 * p + 1 - s);
    endfunction

    task automatic check_out(bit ticked);
        bit live = ticked && m_run;
        if (live) dn_exp = exp_dn(tk, P);
        chk("R2 carrier strobe", int'(mst_pulse), live ? int'(exp_pulse(tk, P)) : 0);
        chk("R4 status level", int'(mst_down), int'(dn_exp));
        for (int s = 0; s < NS; s++)
            chk(s == 0 ? "R7 trigger ch0" : "R9 trigger ch1", int'(slv_trig[s]),
                (live && s_run[s]) ? int'(exp_trig(tk, P, S[s])) : 0);
    endtask

    task automatic do_tick();
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
        if (m_run) tk++;
        check_out(1'b1);
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            check_out(1'b0);
        end
    endtask

    task automatic start_all(int p, int s0, int s1);
        P = p; S[0] = s0; S[1] = s1;
        mst_period = 16'(p);
        slv_cmp = {16'(s1), 16'(s0)};
        mst_start = 1'b1; slv_start = '1;
        @(negedge clk);
        mst_start = 1'b0; slv_start = '0;
        m_run = 1; s_run[0] = 1; s_run[1] = 1; tk = -1; dn_exp = 1;
        chk("R1 status high after start", int'(mst_down), 1);
        chk("R1 no strobe at start", int'(mst_pulse), 0);
    endtask

    task automatic stop_all();
        mst_stop = 1'b1; slv_stop = '1;
        @(negedge clk);
        mst_stop = 1'b0; slv_stop = '0;
        m_run = 0; s_run[0] = 0; s_run[1] = 0;
        check_out(1'b0);
    endtask

    task automatic seg(int p, int s0, int s1, int n);
        start_all(p, s0, s1);
        for (int k = 0; k < n; k++) do_tick();
        stop_all();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset strobe low", int'(mst_pulse), 0);
        chk("R4 reset status high", int'(mst_down), 1);
        chk("R6 reset triggers low", int'(slv_trig), 0);

        // R10 boundaries: S at 1 and at P; smallest period
        seg(1, 1, 1, 12);
        seg(5, 5, 1, 30);
        seg(7, 3, 7, 40);
        for (int r = 0; r < 8; r++) begin
            int p = $urandom_range(1, 20);
            seg(p, $urandom_range(1, p), $urandom_range(1, p), 5 * p + 10);
        end

        // R8: stop freezes status and silences strobes
        start_all(4, 2, 3);
        for (int k = 0; k < 7; k++) do_tick();
        stop_all();
        for (int k = 0; k < 6; k++) do_tick();

        // R8: stop wins over start in the same cycle
        mst_start = 1'b1; mst_stop = 1'b1; slv_start = '1; slv_stop = '1;
        @(negedge clk);
        mst_start = 1'b0; mst_stop = 1'b0; slv_start = '0; slv_stop = '0;
        for (int k = 0; k < 6; k++) do_tick();

        // R9: stopping channel 1 leaves carrier and channel 0 running
        start_all(6, 2, 4);
        for (int k = 0; k < 10; k++) do_tick();
        slv_stop = 2'b10;
        @(negedge clk);
        slv_stop = '0;
        s_run[1] = 0;
        check_out(1'b0);
        for (int k = 0; k < 30; k++) do_tick();
        stop_all();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1500us;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule